// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Ready Flags

This block is a first-in first-out buffer of 64 words, 5 bits each. It stores words in a dual-port memory and keeps separate write and read pointers, so a store and a removal can take place at the same time. The writer and the reader each work with a single strobe. The writer raises `shin` to offer a word and lowers it to commit the word. The reader raises `shout` to take the presented word and lowers it to move on. Both strobes are sampled on the system clock `clk`, and their edges are found from one registered copy of each strobe.

The writer watches `in_rdy`. The reader watches `out_rdy` together with `dout`. A word written into an empty buffer falls through to `dout` one clock after it is committed. When the buffer runs dry, the last word taken stays on `dout`. Two coarse level flags report the fill level: one shows at least half full, and the other shows that the buffer is near either end. `out_hiz` turns the data outputs off. A synchronous master reset `rst` empties the buffer.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high, `in_rdy` is 0, `out_rdy` is 0, `dout` is 0, `half_full` is 0 and `edge_level` is 1, even when the buffer held 64 words before reset. On the first clock edge after `rst` is released, `in_rdy` goes to 1.
- R2: A sampled 0→1 change of `shin` stores `din` and drives `in_rdy` low on that clock edge. The next sampled 1→0 change commits the word, and `in_rdy` returns high on that edge if fewer than 64 words are now held.
- R3: While 64 words are held, `in_rdy` stays low and a `shin` pulse is ignored. Its word is never delivered.
- R4: When the buffer is full, `in_rdy` goes high on the clock edge where a `shout` falling edge commits a removal.
- R5: A word committed into an empty buffer appears on `dout` with `out_rdy` high one clock edge after the commit edge.
- R6: A rising `shout` while `out_rdy` is high drives `out_rdy` low. The falling `shout` removes the word, and one clock edge later the next word, if one is held, is presented with `out_rdy` high.
- R7: Words leave in the order they were committed, across all 64 locations.
- R8: When the buffer is empty, `out_rdy` stays low and `dout` keeps the last word removed. A `shout` pulse while empty is ignored.
- R9: `half_full` is 1 exactly when 32 or more words are held. This count includes the presented word.
- R10: `edge_level` is 1 exactly when 8 or fewer words, or 56 or more words, are held.
- R11: While `out_hiz` is 1, `dout` is high impedance. While it is 0, `dout` drives the presented word.
- R12: A write and a removal that happen in the same clock cycles keep the word order and leave the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous master reset, active high |
| shin | input | 1 | Write strobe: rising edge stores `din`, falling edge commits it |
| din | input | 5 | Word to write |
| in_rdy | output | 1 | High when a word may be written |
| shout | input | 1 | Read strobe: rising edge takes the word, falling edge advances |
| dout | output | 5 | Presented word, high impedance while `out_hiz` is 1 |
| out_rdy | output | 1 | High when `dout` carries a word not yet taken |
| out_hiz | input | 1 | Puts `dout` into high impedance when 1 |
| half_full | output | 1 | 32 or more words held |
| edge_level | output | 1 | 8 or fewer, or 56 or more, words held |

## Verification
The main function is driven with four patterns:
- A few words through an empty buffer. This separates the fall-through delay from the ordinary presentation of the next word.
- A full 64-word fill followed by a full drain. This checks ordering, both level flags at every count, and the wrap of both pointers.
- A write attempt while full and a read attempt while empty. These show that the ignored strobes leave data and pointers untouched.
- A write and a read strobed in the same cycles. This shows whether simultaneous commits disturb the count or the order.

Reset is also applied while the buffer is full, which tells the forced-low `in_rdy` during reset apart from the normal full condition.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int SF_WIDTH_DEF = 5;
    localparam int SF_DEPTH_DEF = 64;

    // Next location of a circular pointer over `depth` slots.
    function automatic int wrap_next(input int ptr, input int depth);
        return (ptr + 1 >= depth) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise = strobe & ~prev_q;
    assign fall = ~strobe & prev_q;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
    parameter int DEPTH     = 64,
    parameter int CW        = 7,
    parameter int LOW_MARK  = 8,
    parameter int HIGH_MARK = 56
) (
    input  logic [CW-1:0] level,
    output logic          half,
    output logic          near_end
);
    localparam int HALF = DEPTH / 2;

    assign half     = level >= CW'(HALF);
    assign near_end = (level <= CW'(LOW_MARK)) || (level >= CW'(HIGH_MARK));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int WIDTH     = SF_WIDTH_DEF,
    parameter int DEPTH     = SF_DEPTH_DEF,
    parameter int LOW_MARK  = 8,
    parameter int HIGH_MARK = 56
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shin,
    input  logic [WIDTH-1:0] din,
    output logic             in_rdy,
    input  logic             shout,
    output logic [WIDTH-1:0] dout,
    output logic             out_rdy,
    input  logic             out_hiz,
    output logic             half_full,
    output logic             edge_level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    count;
        logic             wr_pend;
        logic             so_pend;
        logic             in_rdy;
        logic             out_rdy;
        logic [WIDTH-1:0] dq;
        logic             hf;
        logic             lvl;
    } state_t;

    localparam state_t RST_ST = '{
        wptr: '0, rptr: '0, count: '0, wr_pend: 1'b0, so_pend: 1'b0,
        in_rdy: 1'b0, out_rdy: 1'b0, dq: '0, hf: 1'b0, lvl: 1'b1
    };

    state_t st_d, st_q;

    logic si_rise, si_fall, so_rise, so_fall;
    logic wr_accept, wr_commit, rd_commit, present, full;
    logic [CW-1:0] cnt_nx;
    logic [WIDTH-1:0] rd_data;
    logic hf_nx, lvl_nx;

    strobe_edge u_si_edge (.clk(clk), .rst(rst), .strobe(shin),  .rise(si_rise), .fall(si_fall));
    strobe_edge u_so_edge (.clk(clk), .rst(rst), .strobe(shout), .rise(so_rise), .fall(so_fall));

    fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_accept),
        .waddr (st_q.wptr),
        .wdata (din),
        .raddr (st_q.rptr),
        .rdata (rd_data)
    );

    assign full      = st_q.count == CW'(DEPTH);
    assign wr_accept = si_rise && !full && !st_q.wr_pend && !rst;
    assign wr_commit = si_fall && st_q.wr_pend;
    assign rd_commit = so_fall && st_q.so_pend;
    assign present   = !st_q.out_rdy && !st_q.so_pend && (st_q.count != '0);

    always_comb begin
        unique case ({wr_commit, rd_commit})
            2'b10:   cnt_nx = st_q.count + CW'(1);
            2'b01:   cnt_nx = st_q.count - CW'(1);
            default: cnt_nx = st_q.count;
        endcase
    end

    fifo_level_flags #(
        .DEPTH(DEPTH), .CW(CW), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
    ) u_flags (
        .level    (cnt_nx),
        .half     (hf_nx),
        .near_end (lvl_nx)
    );

    always_comb begin
        st_d = st_q;
        // write side: capture on rise, advance on fall
        if (wr_accept) st_d.wr_pend = 1'b1;
        if (wr_commit) begin
            st_d.wr_pend = 1'b0;
            st_d.wptr    = AW'(wrap_next(int'(st_q.wptr), DEPTH));
        end
        // read side: take on rise, advance on fall, present when idle
        if (rd_commit) begin
            st_d.so_pend = 1'b0;
            st_d.rptr    = AW'(wrap_next(int'(st_q.rptr), DEPTH));
        end
        if (so_rise && st_q.out_rdy) begin
            st_d.out_rdy = 1'b0;
            st_d.so_pend = 1'b1;
        end else if (present) begin
            st_d.dq      = rd_data;
            st_d.out_rdy = 1'b1;
        end
        st_d.count  = cnt_nx;
        st_d.in_rdy = !st_d.wr_pend && (cnt_nx != CW'(DEPTH));
        st_d.hf     = hf_nx;
        st_d.lvl    = lvl_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_ST;
        else     st_q <= st_d;
    end

    assign in_rdy     = st_q.in_rdy;
    assign out_rdy    = st_q.out_rdy;
    assign half_full  = st_q.hf;
    assign edge_level = st_q.lvl;
    assign dout       = out_hiz ? {WIDTH{1'bz}} : st_q.dq;

    // R3: a write strobe while full leaves nothing pending and input not ready
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (full && si_rise) |=> (!st_q.wr_pend && !in_rdy));

    // R4: a removal from a full buffer reopens the input
    p_refill_r4: assert property (@(posedge clk) disable iff (rst)
        (full && rd_commit) |=> in_rdy);

    // R5: a commit into an empty buffer is presented one edge later
    p_fall_through_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.count == '0 && wr_commit && !rd_commit) |=> ##1 out_rdy);

    // R7: occupancy never passes capacity
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CW'(DEPTH));

    // R8: empty means no ready output, and the held word stays
    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.count == '0) |-> !out_rdy);
    p_hold_last_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.count == '0) |=> $stable(st_q.dq));

    // R9: the half flag only rises through a committed write
    p_half_by_write_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(half_full) |-> $past(wr_commit));
endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;
    localparam int D = 64;

    logic clk = 1'b0;
    logic rst, shin, shout, out_hiz;
    logic [W-1:0] din;
    logic [W-1:0] dout;
    logic in_rdy, out_rdy, half_full, edge_level;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model [$];
    logic [W-1:0] last_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_fifo u_strobe_fifo (
        .clk(clk), .rst(rst), .shin(shin), .din(din), .in_rdy(in_rdy),
        .shout(shout), .dout(dout), .out_rdy(out_rdy), .out_hiz(out_hiz),
        .half_full(half_full), .edge_level(edge_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic flags_chk();
        int n = model.size();
        chk("R9 half_full", 32'(half_full), 32'(n >= 32));
        chk("R10 edge_level", 32'(edge_level), 32'(n <= 8 || n >= 56));
    endtask

    // One write strobe; models acceptance according to R2/R3.
    task automatic push(input logic [W-1:0] d);
        bit room = model.size() < D;
        @(negedge clk); shin = 1'b1; din = d;
        @(negedge clk);
        chk("R2 in_rdy low after rise", 32'(in_rdy), 32'd0);
        shin = 1'b0;
        @(negedge clk);
        if (room) model.push_back(d);
        chk("R2/R3 in_rdy after fall", 32'(in_rdy), 32'(model.size() < D));
    endtask

    // One read strobe; checks the presented word first (R6/R7).
    task automatic pop();
        chk("R6 out_rdy before take", 32'(out_rdy), 32'd1);
        chk("R7 order", 32'(dout), 32'(model[0]));
        last_out = model[0];
        @(negedge clk); shout = 1'b1;
        @(negedge clk);
        chk("R6 out_rdy low after rise", 32'(out_rdy), 32'd0);
        shout = 1'b0;
        @(negedge clk);
        void'(model.pop_front());
        @(negedge clk);
        chk("R6 next presented", 32'(out_rdy), 32'(model.size() > 0));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in_rdy in reset", 32'(in_rdy), 32'd0);
        chk("R1 out_rdy in reset", 32'(out_rdy), 32'd0);
        chk("R1 dout in reset", 32'(dout), 32'd0);
        chk("R1 half_full in reset", 32'(half_full), 32'd0);
        chk("R1 edge_level in reset", 32'(edge_level), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 in_rdy after release", 32'(in_rdy), 32'd1);
        model.delete();
    endtask

    task automatic t_basic();
        push(5'h11);
        chk("R5 not yet presented", 32'(out_rdy), 32'd0);
        @(negedge clk);
        chk("R5 fall-through ready", 32'(out_rdy), 32'd1);
        chk("R5 fall-through data", 32'(dout), 32'h11);
        push(5'h0A);
        push(5'h1E);
        flags_chk();
        pop(); pop(); pop();
        @(negedge clk);
        chk("R8 empty not ready", 32'(out_rdy), 32'd0);
        chk("R8 last word held", 32'(dout), 32'(last_out));
    endtask

    task automatic t_empty_pop();
        @(negedge clk); shout = 1'b1;
        @(negedge clk); shout = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 pop on empty ignored, ready", 32'(out_rdy), 32'd0);
        chk("R8 pop on empty ignored, data", 32'(dout), 32'(last_out));
        push(5'h05);
        @(negedge clk);
        pop();
    endtask

    task automatic t_fill();
        for (int i = 0; i < D; i++) begin
            push(W'((i * 7 + 3) & 31));
            flags_chk();
        end
        @(negedge clk);
        chk("R3 full in_rdy low", 32'(in_rdy), 32'd0);
        push(5'h1F);
        chk("R3 still full", 32'(model.size()), 32'(D));
        chk("R3 in_rdy stays low", 32'(in_rdy), 32'd0);
        pop();
        chk("R4 in_rdy after removal", 32'(in_rdy), 32'd1);
        flags_chk();
        while (model.size() > 0) begin
            pop();
            flags_chk();
        end
        chk("R8 drained", 32'(out_rdy), 32'd0);
        chk("R3 ignored word absent", 32'(dout), 32'(((D - 1) * 7 + 3) & 31));
    endtask

    task automatic t_oe();
        push(5'h16);
        @(negedge clk);
        out_hiz = 1'b1;
        @(negedge clk);
        chk("R11 outputs off", 32'(dout), {27'd0, 5'bzzzzz});
        out_hiz = 1'b0;
        @(negedge clk);
        chk("R11 outputs back", 32'(dout), 32'h16);
        pop();
    endtask

    task automatic t_concurrent();
        push(5'h03);
        push(5'h0C);
        @(negedge clk);
        chk("R12 head ready", 32'(dout), 32'h03);
        shin = 1'b1; din = 5'h19; shout = 1'b1;
        @(negedge clk);
        shin = 1'b0; shout = 1'b0;
        @(negedge clk);
        void'(model.pop_front());
        model.push_back(5'h19);
        @(negedge clk);
        chk("R12 count kept", 32'(edge_level), 32'd1);
        pop();
        pop();
        chk("R12 empty after two", 32'(out_rdy), 32'd0);
    endtask

    task automatic t_reset_full();
        for (int i = 0; i < D; i++) push(W'(i & 31));
        chk("R1 full before reset", 32'(in_rdy), 32'd0);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 in_rdy low in reset", 32'(in_rdy), 32'd0);
        chk("R1 out_rdy low in reset", 32'(out_rdy), 32'd0);
        chk("R1 dout cleared", 32'(dout), 32'd0);
        rst = 1'b0;
        model.delete();
        @(negedge clk);
        chk("R1 in_rdy high after release", 32'(in_rdy), 32'd1);
        flags_chk();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; shin = 1'b0; shout = 1'b0; out_hiz = 1'b0; din = '0;
        last_out = '0;
        t_reset();
        t_basic();
        t_empty_pop();
        t_fill();
        t_oe();
        t_concurrent();
        t_reset_full();
        finish_run();
    end
endmodule